// File: doc/BRIEF.md
# Baseband Hang Signature Matcher

This block decides whether the receive baseband has locked up, and if so, which kind of lock-up it is. It watches a 32-bit observation word and, on a start strobe, checks that the word stays frozen over a window of qualified samples. A frozen word is then sorted against a small ordered table of masked hang patterns. Each pattern yields a hang code. A frozen word that matches none of the patterns is reported as an unknown hang.

A transmit-side (MAC/DMA) hang detector sits outside this block. The matcher decides whether that detector is consulted. It sends a one-cycle request only when the MAC check is enabled and the baseband check found nothing. It then forwards the detector's answer. Any baseband hang wins, and the MAC check is skipped. Each run ends with a one-cycle done pulse carrying the final 3-bit code.

Top module: `hang_sig_matcher`

## Requirements
- R1: After reset, `done_o` and `mac_req_o` are low and `hang_code_o` is 0.
- R2: The word is captured on the start cycle. If any qualified sample during the window differs from the captured word, the baseband result is 0 (no hang). The run finishes on the cycle after that sample.
- R3: The window spans N_SAMPLES (default 50) samples taken only on cycles where `obs_valid_i` is high. Words presented while `obs_valid_i` is low are ignored. With a stable word and `obs_valid_i` high every cycle, `done_o` rises 51 clocks after the start edge.
- R4: A stable word with (word & 0x7E000B00) == 0x1E000000 gives code 1.
- R5: A stable word with (word & 0x7E000B00) == 0x52000B00 gives code 2.
- R6: A stable word with (word & 0x7E000B00) == 0x18000B00, or with (word & 0x7E7FFFEF) == 0x00702400, gives code 3.
- R7: The patterns are tried in the order of R4, R5, R6, and the first hit wins. A stable word that hits none of them gives code 7.
- R8: When the baseband result is nonzero, `mac_req_o` never pulses and the reported code is the baseband code.
- R9: When the baseband result is 0 and the MAC check is enabled, `mac_req_o` pulses once for one cycle. The reported code is then `mac_code_i` as sampled with `mac_done_i`.
- R10: With the baseband check disabled, no window runs and the baseband result is 0. With both checks disabled, `done_o` rises one clock after the start edge with code 0.
- R11: The enable bits are captured at start. A start strobe during a run is ignored.
- R12: `done_o` is high for exactly one cycle per run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| obs_word_i | input | 32 | Observation word under test |
| obs_valid_i | input | 1 | Qualifies the current word as a sample |
| start_i | input | 1 | Begins a check run when idle |
| bb_chk_en_i | input | 1 | Enables the baseband stability/signature check |
| mac_chk_en_i | input | 1 | Enables consulting the MAC hang detector |
| mac_req_o | output | 1 | One-cycle request to the MAC hang detector |
| mac_done_i | input | 1 | MAC detector has a result |
| mac_code_i | input | 3 | MAC detector result code |
| done_o | output | 1 | One-cycle end-of-run pulse |
| hang_code_o | output | 3 | Final hang code, valid with `done_o` |

## Verification
The assertions assume a few things about the MAC detector: it answers only after a request, it never answers twice, and it never raises `mac_done_i` while the matcher is not waiting. The bench's detector model therefore replies exactly once, a few cycles after each request. The stimulus starts a new run only after the previous done pulse. The one exception is a deliberate extra start inside an active window, which tests that a start during a run is ignored.

// File: rtl/hsm_pkg.sv
package hsm_pkg;

  localparam int OBS_W   = 32;
  localparam int CODE_W  = 3;
  localparam int NUM_SIG = 4;

  localparam logic [CODE_W-1:0] HC_NONE    = 3'd0;
  localparam logic [CODE_W-1:0] HC_DFS     = 3'd1;
  localparam logic [CODE_W-1:0] HC_RIFS    = 3'd2;
  localparam logic [CODE_W-1:0] HC_RXCLR   = 3'd3;
  localparam logic [CODE_W-1:0] HC_UNKNOWN = 3'd7;

  // Ordered pattern table: lower index has higher priority.
  localparam logic [OBS_W-1:0] SIG_MASK [NUM_SIG] = '{
    32'h7E00_0B00, 32'h7E00_0B00, 32'h7E00_0B00, 32'h7E7F_FFEF
  };
  localparam logic [OBS_W-1:0] SIG_VAL [NUM_SIG] = '{
    32'h1E00_0000, 32'h5200_0B00, 32'h1800_0B00, 32'h0070_2400
  };
  localparam logic [CODE_W-1:0] SIG_CODE [NUM_SIG] = '{
    HC_DFS, HC_RIFS, HC_RXCLR, HC_RXCLR
  };

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WIN  = 2'd1,
    ST_CHK  = 2'd2,
    ST_MAC  = 2'd3
  } seq_state_e;

endpackage

// File: rtl/hsm_classifier.sv
module hsm_classifier
  import hsm_pkg::*;
(
  input  logic [OBS_W-1:0]  word_i,
  output logic [CODE_W-1:0] code_o
);

  logic [NUM_SIG-1:0] hit;

  // One masked comparator per table entry.
  for (genvar g = 0; g < NUM_SIG; g++) begin : g_sig
    assign hit[g] = ((word_i & SIG_MASK[g]) == SIG_VAL[g]);
  end

  // Walk from the lowest-priority entry upward so the lowest index wins.
  always_comb begin
    code_o = HC_UNKNOWN;
    for (int i = NUM_SIG - 1; i >= 0; i--) begin
      if (hit[i]) code_o = SIG_CODE[i];
    end
  end

endmodule

// File: rtl/hsm_sampler.sv
module hsm_sampler #(
  parameter int N_SAMPLES = 50,
  parameter int W         = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_i,
  input  logic [W-1:0] word_i,
  input  logic         valid_i,
  output logic [W-1:0] ref_o,
  output logic         end_o,
  output logic         stable_o
);

  localparam int CNT_W = (N_SAMPLES > 1) ? $clog2(N_SAMPLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(N_SAMPLES - 1);

  logic [W-1:0]     ref_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             mismatch, last_hit, cnt_en;

  always_comb begin
    mismatch = busy_q & valid_i & (word_i != ref_q);
    last_hit = busy_q & valid_i & ~mismatch & (cnt_q == LAST);
    end_o    = mismatch | last_hit;
    stable_o = last_hit;

    busy_d = busy_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (cap_i) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (end_o) begin
      busy_d = 1'b0;
    end else if (busy_q && valid_i) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      ref_q  <= '0;
    end else begin
      busy_q <= busy_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (cap_i)  ref_q <= word_i;
    end
  end

  assign ref_o = ref_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= LAST)) else $error("window count overrun"); // R3

  AST_REF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !cap_i) |=> $stable(ref_q)) else $error("reference moved"); // R2

endmodule

// File: rtl/hsm_sequencer.sv
module hsm_sequencer
  import hsm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              bb_en_i,
  input  logic              mac_en_i,
  input  logic              win_end_i,
  input  logic              win_stable_i,
  input  logic [CODE_W-1:0] bb_code_i,
  input  logic              mac_done_i,
  input  logic [CODE_W-1:0] mac_code_i,
  output logic              cap_o,
  output logic              mac_req_o,
  output logic              done_o,
  output logic [CODE_W-1:0] code_o
);

  seq_state_e        state_q, state_d;
  logic [CODE_W-1:0] bb_q, bb_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              mac_en_q, mac_en_ld;
  logic              done_q, done_d;
  logic              bb_ld;

  always_comb begin
    state_d   = state_q;
    bb_d      = bb_q;
    bb_ld     = 1'b0;
    code_d    = code_q;
    done_d    = 1'b0;
    mac_en_ld = 1'b0;
    cap_o     = 1'b0;
    mac_req_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          mac_en_ld = 1'b1;
          bb_ld     = 1'b1;
          bb_d      = HC_NONE;
          if (bb_en_i) begin
            cap_o   = 1'b1;
            state_d = ST_WIN;
          end else begin
            state_d = ST_CHK;
          end
        end
      end
      ST_WIN: begin
        if (win_end_i) begin
          bb_ld   = 1'b1;
          bb_d    = win_stable_i ? bb_code_i : HC_NONE;
          state_d = ST_CHK;
        end
      end
      ST_CHK: begin
        if ((bb_q != HC_NONE) || !mac_en_q) begin
          done_d  = 1'b1;
          code_d  = bb_q;
          state_d = ST_IDLE;
        end else begin
          mac_req_o = 1'b1;
          state_d   = ST_MAC;
        end
      end
      ST_MAC: begin
        if (mac_done_i) begin
          done_d  = 1'b1;
          code_d  = mac_code_i;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bb_q     <= HC_NONE;
      code_q   <= HC_NONE;
      mac_en_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (bb_ld)     bb_q     <= bb_d;
      if (done_d)    code_q   <= code_d;
      if (mac_en_ld) mac_en_q <= mac_en_i;
    end
  end

  assign done_o = done_q;
  assign code_o = code_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o) else $error("done longer than one cycle"); // R12

  AST_MAC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MAC) |-> (bb_q == HC_NONE)) else $error("MAC check after baseband hang"); // R8

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mac_req_o |=> !mac_req_o) else $error("MAC request not a pulse"); // R9

  AST_SKIP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start_i && !bb_en_i) |=> (state_q == ST_CHK)) else $error("window ran while disabled"); // R10

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WIN && start_i && !win_end_i) |=> (state_q == ST_WIN)) else $error("start disturbed a run"); // R11

endmodule

// File: rtl/hang_sig_matcher.sv
module hang_sig_matcher #(
  parameter int N_SAMPLES = 50
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] obs_word_i,
  input  logic        obs_valid_i,
  input  logic        start_i,
  input  logic        bb_chk_en_i,
  input  logic        mac_chk_en_i,
  output logic        mac_req_o,
  input  logic        mac_done_i,
  input  logic [2:0]  mac_code_i,
  output logic        done_o,
  output logic [2:0]  hang_code_o
);
  import hsm_pkg::*;

  logic [OBS_W-1:0]  ref_word;
  logic [CODE_W-1:0] bb_code;
  logic              cap, win_end, win_stable;

  hsm_sampler #(.N_SAMPLES(N_SAMPLES), .W(OBS_W)) u_smp (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_i    (cap),
    .word_i   (obs_word_i),
    .valid_i  (obs_valid_i),
    .ref_o    (ref_word),
    .end_o    (win_end),
    .stable_o (win_stable)
  );

  hsm_classifier u_cls (
    .word_i (ref_word),
    .code_o (bb_code)
  );

  hsm_sequencer u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .bb_en_i      (bb_chk_en_i),
    .mac_en_i     (mac_chk_en_i),
    .win_end_i    (win_end),
    .win_stable_i (win_stable),
    .bb_code_i    (bb_code),
    .mac_done_i   (mac_done_i),
    .mac_code_i   (mac_code_i),
    .cap_o        (cap),
    .mac_req_o    (mac_req_o),
    .done_o       (done_o),
    .code_o       (hang_code_o)
  );

  AST_REQ_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    mac_req_o |-> !done_o) else $error("request and done together"); // R9

endmodule

// File: tb/sim_hang_sig_matcher.sv
module sim_hang_sig_matcher;

  typedef struct {
    logic [2:0] code;
    int         lat;
    int         macs;
    int         scyc;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] obs_word = '0;
  logic        obs_valid = 1'b0;
  logic        start = 1'b0;
  logic        bb_en = 1'b0;
  logic        mac_en = 1'b0;
  logic        mac_req;
  logic        mac_done = 1'b0;
  logic [2:0]  mac_code = '0;
  logic        done;
  logic [2:0]  code;

  logic [2:0]  mac_resp = '0;
  int          cyc = 0;
  int          n_chk = 0;
  int          n_fail = 0;
  int          mac_cnt = 0;
  bit          prev_done = 1'b0;
  bit          finished = 1'b0;
  exp_t        sb [$];

  always #2.5 clk = ~clk;

  hang_sig_matcher u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .obs_word_i   (obs_word),
    .obs_valid_i  (obs_valid),
    .start_i      (start),
    .bb_chk_en_i  (bb_en),
    .mac_chk_en_i (mac_en),
    .mac_req_o    (mac_req),
    .mac_done_i   (mac_done),
    .mac_code_i   (mac_code),
    .done_o       (done),
    .hang_code_o  (code)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // MAC detector model: one reply a few cycles after each request.
  initial begin
    forever begin
      @(negedge clk);
      if (mac_req) begin
        repeat (3) @(negedge clk);
        mac_code = mac_resp;
        mac_done = 1'b1;
        @(negedge clk);
        mac_done = 1'b0;
      end
    end
  end

  // Monitor: pops expected results as done pulses appear.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (prev_done) check(!done, "R12 done width", int'(done), 0);
      if (mac_req) mac_cnt++;
      if (done) begin
        if (sb.size() == 0) begin
          check(1'b0, "R12 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(code == e.code, {e.tag, " code"}, int'(code), int'(e.code));
          if (e.lat >= 0) check((cyc - e.scyc - 1) == e.lat, {e.tag, " latency"}, cyc - e.scyc - 1, e.lat);
          check(mac_cnt == e.macs, {e.tag, " mac requests"}, mac_cnt, e.macs);
        end
        mac_cnt = 0;
      end
      prev_done = done;
    end
  end

  task automatic run_case(input logic [31:0] w, input int chg, input bit gaps,
                          input bit bb, input bit mac, input logic [2:0] resp,
                          input logic [2:0] ecode, input int elat, input int emac,
                          input bit extra, input string tag);
    exp_t e;
    int   i;
    @(negedge clk);
    e.code = ecode; e.lat = elat; e.macs = emac; e.scyc = cyc; e.tag = tag;
    sb.push_back(e);
    mac_resp  = resp;
    obs_word  = w;
    obs_valid = 1'b1;
    bb_en     = bb;
    mac_en    = mac;
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    i = 1;
    while (sb.size() != 0 && i < 2000) begin
      obs_valid = gaps ? (i % 2 == 0) : 1'b1;
      if (!obs_valid)                obs_word = ~w;
      else if (chg > 0 && i >= chg)  obs_word = w ^ 32'h0000_0001;
      else                           obs_word = w;
      if (extra && i == 10) begin
        start = 1'b1; bb_en = 1'b0; mac_en = 1'b1;
      end else begin
        start = 1'b0; bb_en = bb; mac_en = mac;
      end
      @(negedge clk);
      i++;
    end
    start = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!done && code == 3'd0 && !mac_req, "R1 reset outputs", int'(done) + int'(code) + int'(mac_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && code == 3'd0 && !mac_req, "R1 after release", int'(done) + int'(code) + int'(mac_req), 0);

    run_case(32'h9E00_40F0, 0, 0, 1, 0, 3'd0, 3'd1, 51, 0, 0, "R4 DFS pattern / R3 window");
    run_case(32'hD201_2B45, 0, 0, 1, 0, 3'd0, 3'd2, 51, 0, 0, "R5 RIFS pattern");
    run_case(32'h18F0_0BA0, 0, 0, 1, 0, 3'd0, 3'd3, 51, 0, 0, "R6 rx-clear pattern A");
    run_case(32'h81F0_2410, 0, 0, 1, 0, 3'd0, 3'd3, 51, 0, 0, "R6 rx-clear pattern B");
    run_case(32'h1234_5678, 0, 0, 1, 0, 3'd0, 3'd7, 51, 0, 0, "R7 no pattern");
    run_case(32'h1E00_0100, 0, 0, 1, 0, 3'd0, 3'd7, 51, 0, 0, "R7 near miss");
    run_case(32'h9E00_40F0, 50, 0, 1, 0, 3'd0, 3'd0, 51, 0, 0, "R2 change on last sample");
    run_case(32'h9E00_40F0, 1, 0, 1, 0, 3'd0, 3'd0, 2, 0, 0, "R2 change on first sample");
    run_case(32'h9E00_40F0, 0, 0, 1, 1, 3'd5, 3'd1, 51, 0, 0, "R8 baseband hang skips MAC");
    run_case(32'h1234_5678, 0, 0, 1, 1, 3'd5, 3'd7, 51, 0, 0, "R8 unknown skips MAC");
    run_case(32'h1800_0B00, 20, 0, 1, 1, 3'd5, 3'd5, -1, 1, 0, "R9 unstable then MAC");
    run_case(32'h9E00_40F0, 0, 0, 0, 1, 3'd4, 3'd4, -1, 1, 0, "R10 baseband off, MAC on");
    run_case(32'h9E00_40F0, 0, 0, 0, 0, 3'd6, 3'd0, 1, 0, 0, "R10 both off");
    run_case(32'hD201_2B45, 0, 1, 1, 0, 3'd0, 3'd2, -1, 0, 0, "R3 gaps ignored");
    run_case(32'h18F0_0BA0, 0, 0, 1, 0, 3'd6, 3'd3, 51, 0, 1, "R11 start during run");

    check(sb.size() == 0, "R12 all runs completed", sb.size(), 0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule